// File: doc/BRIEF.md
# Three-Master Backplane Bus Arbiter

This block sits on the board of the default bus master and decides which of up to three masters owns a shared asynchronous backplane. The default (local) master asks for the bus with an active-high request. Two potential masters elsewhere on the backplane use active-low request lines and get back active-low grant lines. The local master gets an active-high grant.

Ownership parks on the local master whenever nobody else wants the bus. A potential master keeps its grant for as long as it holds its request. The bus changes hands only while the address strobe is idle. Between any two owners there is exactly one clock with no grant active, so two masters never drive the bus together. When the bus is free, a potential master's request turns into a grant two clocks after it is first sampled.

All inputs are assumed to be synchronous to `clk`. Synchronising lines that come from the backplane is the job of the surrounding logic.

Top module: `arb3_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, and after that edge, the arbiter parks on the local master: `loc_gnt`=1 and `pm_gnt_n`=2'b11.
- R2: At most one of `loc_gnt`, `~pm_gnt_n[0]` and `~pm_gnt_n[1]` is active in any cycle.
- R3: Suppose the local master is parked with `loc_req`=0, `adr_stb_n`=1, and a potential master pulls its request low (bit k of `pm_req_n` = 0). At the first edge that samples the request, all grants drop. At the next edge, `pm_gnt_n[k]` goes low. The grant therefore appears two clocks after the request is sampled.
- R4: When a grant is issued with both potential requests low, `pm_gnt_n[0]` wins over `pm_gnt_n[1]`. Either potential master wins over the local master.
- R5: A potential master that owns the bus keeps its grant while its own request stays low, whatever the other request lines and the strobe do.
- R6: An owner that has dropped its request keeps its grant as long as `adr_stb_n`=0. It releases at the first edge that samples `adr_stb_n`=1.
- R7: When an owner releases, there is exactly one cycle with all grants inactive, provided `adr_stb_n`=1 at the following edge. After that cycle the next owner is granted.
- R8: If neither potential master is requesting when the bus is handed over, ownership goes to the local master. It stays there for as long as no potential request is low, whether `loc_req` is high or low.
- R9: While the local master owns the bus and `loc_req`=1, it keeps the grant even if potential masters are requesting.
- R10: During the idle cycle, a sampled `adr_stb_n`=0 delays the new grant. The arbiter stays idle until it samples `adr_stb_n`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| loc_req | input | 1 | Local (default) master holds or wants the bus, active high |
| pm_req_n | input | 2 | Potential master requests, active low; bit 0 has the higher priority |
| adr_stb_n | input | 1 | Backplane address strobe, active low; low means a transfer is in progress |
| loc_gnt | output | 1 | Local master owns the bus, active high |
| pm_gnt_n | output | 2 | Potential master grants, active low, one per request line |

## Verification
The hardest cases to reach are those where the strobe is still active at the very edge where a handover would otherwise happen. One is an owner that has already dropped its request. The other is the idle cycle itself. Directed sequences put `adr_stb_n` low at exactly those edges and then release it, so that the hold and the delayed grant can be seen on the ports. A long pseudo-random sweep driven by an LFSR then runs through every combination of requests and strobe from every ownership state, and each cycle is compared against an ownership model the bench derives from the requirements.

// File: rtl/arb3_pkg.sv
// Shared types for the three-master arbiter.
// Assumes: exactly one local master and two potential masters.
package arb3_pkg;

    // Bus ownership; OWN_GAP is the dead cycle in which nobody holds a grant.
    typedef enum logic [1:0] {
        OWN_LOC = 2'd0,
        OWN_P0  = 2'd1,
        OWN_P1  = 2'd2,
        OWN_GAP = 2'd3
    } owner_e;

    localparam int unsigned NUM_PM = 2;

endpackage

// File: rtl/arb3_pick.sv
// Priority picker: selects the next owner among the requesters.
// Order is potential 0, then potential 1, then the local master,
// which is also the parking default when nobody asks.
// Assumes: req_p is active high and already synchronous.
module arb3_pick
    import arb3_pkg::*;
(
    input  logic [NUM_PM-1:0] req_p,
    output owner_e            winner
);

    // Fixed-priority choice of the next owner.
    always_comb begin
        if (req_p[0])      winner = OWN_P0;
        else if (req_p[1]) winner = OWN_P1;
        else               winner = OWN_LOC;
    end

    // R4
    always_comb begin
        prio_order_chk: assert (!req_p[0] || winner == OWN_P0);
    end

endmodule

// File: rtl/arb3_release.sv
// Release detector: says when the current owner has finished with the bus.
// The local master gives up the bus only when it is not requesting and a
// potential master is waiting. A potential master gives it up when it
// drops its request. Either way the strobe must be idle.
// Assumes: strobe_idle is high when no transfer is in progress.
module arb3_release
    import arb3_pkg::*;
(
    input  owner_e            owner,
    input  logic              loc_req,
    input  logic [NUM_PM-1:0] req_p,
    input  logic              strobe_idle,
    output logic              release_now
);

    logic done;

    // Decide whether the present owner is finished.
    always_comb begin
        unique case (owner)
            OWN_LOC: done = !loc_req && (|req_p);
            OWN_P0:  done = !req_p[0];
            OWN_P1:  done = !req_p[1];
            default: done = 1'b0;
        endcase
    end

    // A finished owner may let go only while the strobe is idle.
    assign release_now = done && strobe_idle;

endmodule

// File: rtl/arb3_seq.sv
// Ownership sequencer: holds the owner register. It moves to the dead
// cycle on release, then hands the bus to the picker's winner once the
// strobe is idle.
// Assumes: synchronous active-low reset; reset parks on the local master.
module arb3_seq
    import arb3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              release_now,
    input  logic              strobe_idle,
    input  logic [NUM_PM-1:0] req_p,
    input  owner_e            winner,
    output owner_e            owner
);

    owner_e owner_q;
    owner_e owner_d;

    // Next-owner logic: hold, enter the gap, or leave the gap.
    always_comb begin
        owner_d = owner_q;
        if (owner_q == OWN_GAP) begin
            if (strobe_idle) owner_d = winner;
        end else if (release_now) begin
            owner_d = OWN_GAP;
        end
    end

    // Owner register with synchronous reset to the parking owner.
    always_ff @(posedge clk) begin
        if (!rst_n) owner_q <= OWN_LOC;
        else        owner_q <= owner_d;
    end

    assign owner = owner_q;

    // R5
    p0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == OWN_P0 && req_p[0]) |=> owner_q == OWN_P0);

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q != OWN_GAP && !strobe_idle) |=> $stable(owner_q));

    // R7
    via_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q != OWN_GAP) |=> (owner_q == $past(owner_q) || owner_q == OWN_GAP));

    // R10
    gap_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_q == OWN_GAP && !strobe_idle) |=> owner_q == OWN_GAP);

endmodule

// File: rtl/arb3_top.sv
// Three-master bus arbiter for the default-master board.
// It turns the active-low backplane lines into internal active-high form,
// picks and sequences ownership, and decodes the owner into grants.
// Assumes: every input is synchronous to clk.
module arb3_top
    import arb3_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_req,
    input  logic [NUM_PM-1:0] pm_req_n,
    input  logic              adr_stb_n,
    output logic              loc_gnt,
    output logic [NUM_PM-1:0] pm_gnt_n
);

    logic [NUM_PM-1:0] req_p;
    logic              strobe_idle;
    logic              release_now;
    owner_e            winner;
    owner_e            owner;

    assign req_p       = ~pm_req_n;
    assign strobe_idle = adr_stb_n;

    arb3_pick u_pick (
        .req_p  (req_p),
        .winner (winner)
    );

    arb3_release u_rel (
        .owner       (owner),
        .loc_req     (loc_req),
        .req_p       (req_p),
        .strobe_idle (strobe_idle),
        .release_now (release_now)
    );

    arb3_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .release_now (release_now),
        .strobe_idle (strobe_idle),
        .req_p       (req_p),
        .winner      (winner),
        .owner       (owner)
    );

    // Decode the owner into one grant line per potential master.
    for (genvar g = 0; g < NUM_PM; g++) begin : g_gnt
        assign pm_gnt_n[g] = (owner != owner_e'(g + 1));
    end

    assign loc_gnt = (owner == OWN_LOC);

    // R2
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({loc_gnt, ~pm_gnt_n}));

    // R8
    park_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_gnt && &pm_req_n) |=> loc_gnt);

endmodule

// File: tb/arb3_top_tb_top.sv
// Bench: directed handover sequences, then an LFSR sweep checked against
// an ownership model written from the requirements.
module arb3_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loc_req = 1'b0;
    logic [1:0] pm_req_n = 2'b11;
    logic       adr_stb_n = 1'b1;
    logic       loc_gnt;
    logic [1:0] pm_gnt_n;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    arb3_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .loc_req   (loc_req),
        .pm_req_n  (pm_req_n),
        .adr_stb_n (adr_stb_n),
        .loc_gnt   (loc_gnt),
        .pm_gnt_n  (pm_gnt_n)
    );

    // Model owner: 0 local, 1 potential 0, 2 potential 1, 3 gap.
    int m_own = 0;
    always @(posedge clk) begin
        if (!rst_n) m_own <= 0;
        else begin
            case (m_own)
                0: if (!loc_req && adr_stb_n && pm_req_n != 2'b11) m_own <= 3;
                1: if (pm_req_n[0] && adr_stb_n) m_own <= 3;
                2: if (pm_req_n[1] && adr_stb_n) m_own <= 3;
                default: if (adr_stb_n)
                    m_own <= !pm_req_n[0] ? 1 : (!pm_req_n[1] ? 2 : 0);
            endcase
        end
    end

    task automatic expect_gnt(input string tag, input logic elg, input logic [1:0] epg);
        n_chk++;
        if (loc_gnt !== elg || pm_gnt_n !== epg) begin
            n_bad++;
            $display("FAIL %s: got loc_gnt=%b pm_gnt_n=%b, expected loc_gnt=%b pm_gnt_n=%b",
                     tag, loc_gnt, pm_gnt_n, elg, epg);
        end
    endtask

    // Drive inputs at a falling edge; return one rising edge later.
    task automatic cyc(input logic l, input logic [1:0] rn, input logic s);
        loc_req = l; pm_req_n = rn; adr_stb_n = s;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++; n_chk++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [15:0] lfsr;
        logic        elg;
        logic [1:0]  epg;
        @(negedge clk);
        cyc(0, 2'b11, 1); cyc(0, 2'b11, 1);
        expect_gnt("R1 reset parks local", 1, 2'b11);
        rst_n = 1'b1;
        cyc(0, 2'b11, 1); cyc(0, 2'b11, 1); cyc(1, 2'b11, 1);
        expect_gnt("R8 idle parks local", 1, 2'b11);
        // R3: two clocks to grant on a free bus
        cyc(0, 2'b10, 1);
        expect_gnt("R3/R7 gap after request", 0, 2'b11);
        cyc(0, 2'b10, 1);
        expect_gnt("R3 grant potential 0", 0, 2'b10);
        cyc(0, 2'b00, 0); cyc(0, 2'b00, 1);
        expect_gnt("R5 potential 0 holds", 0, 2'b10);
        // R6: drop with the strobe busy
        cyc(0, 2'b01, 0);
        expect_gnt("R6 hold while strobe busy", 0, 2'b10);
        cyc(0, 2'b01, 1);
        expect_gnt("R7 dead cycle", 0, 2'b11);
        cyc(0, 2'b01, 1);
        expect_gnt("R7 next owner potential 1", 0, 2'b01);
        cyc(0, 2'b11, 1); cyc(0, 2'b11, 1);
        expect_gnt("R8 return to local", 1, 2'b11);
        // R10: gap stretched by a busy strobe
        cyc(0, 2'b01, 1);
        expect_gnt("R10 gap", 0, 2'b11);
        cyc(0, 2'b01, 0);
        expect_gnt("R10 gap held by strobe", 0, 2'b11);
        cyc(0, 2'b01, 1);
        expect_gnt("R10 grant after strobe idle", 0, 2'b01);
        // R4: both requesting at the handover
        cyc(0, 2'b10, 1);
        expect_gnt("R4 gap", 0, 2'b11);
        cyc(0, 2'b00, 1);
        expect_gnt("R4 potential 0 wins", 0, 2'b10);
        // R9: local holds with loc_req high
        cyc(1, 2'b11, 1); cyc(1, 2'b11, 1);
        expect_gnt("R8 local after release", 1, 2'b11);
        cyc(1, 2'b10, 1); cyc(1, 2'b00, 1);
        expect_gnt("R9 local holds", 1, 2'b11);
        cyc(0, 2'b10, 0);
        expect_gnt("R6 local held by strobe", 1, 2'b11);
        cyc(0, 2'b10, 1);
        expect_gnt("R7 gap from local", 0, 2'b11);
        cyc(0, 2'b10, 1);
        expect_gnt("R3 potential 0 after local", 0, 2'b10);
        // Sweep: pseudo-random inputs against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0], lfsr[2:1], lfsr[3] | lfsr[4]);
            elg = (m_own == 0);
            epg = {m_own != 2, m_own != 1};
            expect_gnt("R2/R5/R6/R7/R8/R10 sweep", elg, epg);
            n_chk++;
            if ($countones({loc_gnt, ~pm_gnt_n}) > 1) begin
                n_bad++;
                $display("FAIL R2: got grants %b%b, expected at most one", loc_gnt, ~pm_gnt_n);
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule